// File: doc/BRIEF.md
# Tank Outlet Valve Hysteresis Controller

This block controls the outlet valve of a storage tank using two level sensors. One sensor sits near the top of the tank and one near the bottom. The valve opens only once the tank is full. After that it stays open while the liquid falls between the two sensors, and it closes only when the bottom sensor is exposed. Because the choice between "keep open" and "keep closed" in the middle band depends on what the valve is already doing, the registered valve state is fed back into the decision logic.

The sensor lines are asynchronous. Each passes through a chain of synchroniser flops before the decision logic uses it. The valve drive is taken straight from a state register, so it cannot glitch. A sensor combination that is physically impossible (top covered, bottom dry) opens the valve and raises a fault flag. That flag stays up for as long as the combination lasts.

Top module: `tank_valve_ctrl`

## Requirements
- R1: A synchronous active-high reset drives the valve output to 1 (closed) and the fault flag to 0, whatever state the block was in before.
- R2: The valve output is active low (0 = open, 1 = closed). When both sensors read 1 (covered), it goes to 0, whatever its previous value.
- R3: When only the low sensor reads 1 and the valve is open (0), the valve stays open for as long as that holds.
- R4: When only the low sensor reads 1 and the valve is closed (1), the valve stays closed for as long as that holds.
- R5: When both sensors read 0 (uncovered), the valve output goes to 1.
- R6: When the high sensor reads 1 and the low sensor reads 0, the valve output goes to 0 and the fault flag goes to 1. This holds whether the valve was previously open or closed.
- R7: The fault flag returns to 0 once the high-covered, low-uncovered combination has gone.
- R8: A change on the sensor inputs reaches the outputs exactly SYNC_STAGES+1 rising clock edges later, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lvl_high_i | input | 1 | Upper level sensor, 1 = covered, asynchronous |
| lvl_low_i | input | 1 | Lower level sensor, 1 = covered, asynchronous |
| valve_n_o | output | 1 | Outlet valve drive, 0 = open, 1 = closed |
| sensor_fault_o | output | 1 | High while the sensors report an impossible combination |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This gives a four-edge path from sensor to valve. The bench counts that path exactly: it checks that the output has not yet moved after three edges and has moved after the fourth, so any error in the synchroniser depth or in how the stages are chained shows up as a timing mismatch. With the longer chain, full fill-and-drain cycles and fault entries from both valve states are also run. Each one checks the hold behaviour in the band between the sensors over many cycles.

// File: rtl/tank_pkg.sv
package tank_pkg;

    // Drive level on the valve pin; encoding equals the pin value.
    typedef enum logic {
        VALVE_OPEN = 1'b0,
        VALVE_SHUT = 1'b1
    } valve_t;

    typedef struct packed {
        logic high;
        logic low;
    } level_t;

    localparam int LEVEL_W = $bits(level_t);

    // Impossible reading: top wet while bottom is dry.
    function automatic logic level_bad(input level_t lv);
        return lv.high & ~lv.low;
    endfunction

    // Hysteresis decision with the present valve state fed back.
    function automatic valve_t decide_valve(input level_t lv, input valve_t cur);
        valve_t nxt;
        unique case ({lv.high, lv.low})
            2'b11:   nxt = VALVE_OPEN;
            2'b10:   nxt = VALVE_OPEN;
            2'b01:   nxt = cur;
            default: nxt = VALVE_SHUT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tank_sync.sv
module tank_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= '0;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[LAST];

endmodule

// File: rtl/tank_decide.sv
module tank_decide
    import tank_pkg::*;
(
    input  level_t lvl,
    input  valve_t cur,
    output valve_t nxt,
    output logic   bad
);
    always_comb begin
        nxt = decide_valve(lvl, cur);
        bad = level_bad(lvl);
    end
endmodule

// File: rtl/tank_valve_ctrl.sv
module tank_valve_ctrl
    import tank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_high_i,
    input  logic lvl_low_i,
    output logic valve_n_o,
    output logic sensor_fault_o
);
    level_t raw_lvl;
    level_t sync_lvl;
    valve_t valve_q;
    valve_t valve_d;
    logic   fault_q;
    logic   fault_d;

    assign raw_lvl.high = lvl_high_i;
    assign raw_lvl.low  = lvl_low_i;

    tank_sync #(
        .WIDTH  (LEVEL_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lvl),
        .q   (sync_lvl)
    );

    tank_decide u_decide (
        .lvl (sync_lvl),
        .cur (valve_q),
        .nxt (valve_d),
        .bad (fault_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valve_q <= VALVE_SHUT;
            fault_q <= 1'b0;
        end else begin
            valve_q <= valve_d;
            fault_q <= fault_d;
        end
    end

    assign valve_n_o      = valve_q;
    assign sensor_fault_o = fault_q;

    // R1
    reset_closed_chk: assert property (@(posedge clk)
        rst |=> (valve_n_o == 1'b1 && sensor_fault_o == 1'b0));

    // R2
    full_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_lvl.high && sync_lvl.low) |=> (valve_n_o == 1'b0));

    // R3 R4
    band_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_lvl.high && sync_lvl.low) |=> $stable(valve_n_o));

    // R5
    empty_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_lvl.high && !sync_lvl.low) |=> (valve_n_o == 1'b1));

    // R6
    fault_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_lvl.high && !sync_lvl.low) |=> (valve_n_o == 1'b0 && sensor_fault_o));

    // R7
    fault_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !(sync_lvl.high && !sync_lvl.low) |=> !sensor_fault_o);

endmodule

// File: tb/tank_valve_ctrl_bench.sv
module tank_valve_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STAGES     = 3;
    localparam int LAT        = STAGES + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hi  = 1'b0;
    logic lo  = 1'b0;
    logic valve_n;
    logic fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tank_valve_ctrl #(.SYNC_STAGES(STAGES)) u_tank_valve_ctrl (
        .clk            (clk),
        .rst            (rst),
        .lvl_high_i     (hi),
        .lvl_low_i      (lo),
        .valve_n_o      (valve_n),
        .sensor_fault_o (fault)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Drive sensors at a falling edge, then wait until the result is visible.
    task automatic apply(input logic h, input logic l);
        @(negedge clk);
        hi = h;
        lo = l;
        repeat (LAT) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        hi = 1'b0;
        lo = 1'b0;
        idle(LAT + 1);
        check("R1", "valve after reset", valve_n, 1'b1);
        check("R1", "fault after reset", fault, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_fill_drain();
        apply(1'b0, 1'b1);
        check("R4", "low only, was closed", valve_n, 1'b1);
        idle(12);
        check("R4", "low only, still closed", valve_n, 1'b1);
        apply(1'b1, 1'b1);
        check("R2", "both covered opens", valve_n, 1'b0);
        check("R2", "no fault when full", fault, 1'b0);
        apply(1'b0, 1'b1);
        check("R3", "low only, was open", valve_n, 1'b0);
        idle(12);
        check("R3", "low only, still open", valve_n, 1'b0);
        apply(1'b0, 1'b0);
        check("R5", "empty closes", valve_n, 1'b1);
    endtask

    task automatic t_fault();
        apply(1'b1, 1'b0);
        check("R6", "fault from closed opens", valve_n, 1'b0);
        check("R6", "fault flag from closed", fault, 1'b1);
        idle(5);
        check("R6", "fault flag persists", fault, 1'b1);
        apply(1'b0, 1'b0);
        check("R7", "fault clears on empty", fault, 1'b0);
        check("R5", "closed after fault", valve_n, 1'b1);
        apply(1'b1, 1'b1);
        check("R2", "open before fault", valve_n, 1'b0);
        apply(1'b1, 1'b0);
        check("R6", "fault from open keeps open", valve_n, 1'b0);
        check("R6", "fault flag from open", fault, 1'b1);
        apply(1'b1, 1'b1);
        check("R7", "fault clears on full", fault, 1'b0);
        check("R2", "still open", valve_n, 1'b0);
        apply(1'b0, 1'b0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        hi = 1'b1;
        lo = 1'b1;
        repeat (STAGES) @(posedge clk);
        @(negedge clk);
        check("R8", "not yet open", valve_n, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check("R8", "open on exact edge", valve_n, 1'b0);
        @(negedge clk);
        hi = 1'b1;
        lo = 1'b0;
        repeat (STAGES) @(posedge clk);
        @(negedge clk);
        check("R8", "fault not yet", fault, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R8", "fault on exact edge", fault, 1'b1);
    endtask

    task automatic t_reset_open();
        apply(1'b1, 1'b1);
        check("R2", "open before reset", valve_n, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "reset closes open valve", valve_n, 1'b1);
        check("R1", "reset clears fault", fault, 1'b0);
        rst = 1'b0;
        hi = 1'b0;
        lo = 1'b0;
        idle(LAT);
    endtask

    initial begin
        t_reset();
        t_fill_drain();
        t_fault();
        apply(1'b0, 1'b0);
        t_latency();
        t_reset_open();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule